// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A cycle-accurate, synthesizable model of a pipelined synchronous static RAM. The word is 18 bits wide and split into two 9-bit lanes that can be written separately. The depth is a parameter and is kept small for simulation. There are two ways to open an access. The first is a processor-side strobe, which only counts while the primary chip enable is active. The second is a controller-side strobe, which always counts. Each opening loads an address into an internal burst counter. Later cycles either hold that address or step it through a four-location window.

Writes are decoded from three sources: a global write, a lane-write qualifier and one enable per lane. The full word can be written in two ways, and a partial write touches only the enabled lanes. Reads go through a registered pipeline. The output bus is modelled as tri-state: `rdata_oe` marks the cycles in which the model drives `rdata`, and `rdata` reads zero in all other cycles. Deselection takes effect one cycle after the chip enables go inactive.

Top module: `sbsram_core`

## Requirements
- R1: An access opens as selected only if, on the same edge, `sel0_n`=0, `sel1_n`=0 and `sel2`=1. An opening without all three is a deselect: it writes nothing, it starts no read, and later cycles have no effect until the next opening.
- R2: A processor-strobe opening (`adr_proc_n`=0 with `sel0_n`=0) loads `addr` and performs no write in that cycle, whatever the write controls are.
- R3: `adr_proc_n`=0 is ignored while `sel0_n`=1. During an active burst, such a cycle behaves as an ordinary continuation cycle on the current address.
- R4: A controller-strobe opening (`adr_ctrl_n`=0, no processor opening) loads `addr` and restarts the burst, even if `burst_adv_n`=0 in the same cycle. Its write controls take effect in that same cycle, at the loaded address.
- R5: In a continuation cycle with `burst_adv_n`=1, the address is held, and any write goes to the held address.
- R6: In a continuation cycle with `burst_adv_n`=0, the address steps first. The low 2 bits count up and wrap (…10, 11, 00, 01), the upper bits never change, and any write goes to the stepped address.
- R7: `all_wr_n`=0 writes all 18 bits.
- R8: With `all_wr_n`=1 and `lane_wr_n`=0, lane k is written only where `lane_en_n[k]`=0. Lane 0 is bits 8:0 and lane 1 is bits 17:9, so both enables low writes the full word. With `all_wr_n`=1 and `lane_wr_n`=1, nothing is written.
- R9: For a read cycle sampled on edge N, the data is on `rdata` with `rdata_oe`=1 after edge N+1, provided `out_en_n`=0.
- R10: `rdata_oe` is 0 in three cases: whenever `out_en_n`=1; in the cycle after edge N+1 when edge N was a write cycle; and from the second edge after a deselect onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control state |
| adr_proc_n | input | 1 | Processor-side address strobe, active low |
| adr_ctrl_n | input | 1 | Controller-side address strobe, active low |
| burst_adv_n | input | 1 | Burst step request, active low |
| sel0_n | input | 1 | Primary chip enable, active low |
| sel1_n | input | 1 | Second chip enable, active low |
| sel2 | input | 1 | Third chip enable, active high |
| all_wr_n | input | 1 | Global full-word write, active low |
| lane_wr_n | input | 1 | Lane-write qualifier, active low |
| lane_en_n | input | 2 | Per-lane write enables, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 18 | Write data |
| rdata | output | 18 | Read data, zero when not driven |
| rdata_oe | output | 1 | High while the model drives `rdata` |

## Verification
The controller strobe and the step request can be active in the same cycle. This is provoked in the middle of a write burst: after one stepped beat, the controller strobe is asserted at a new address together with `burst_adv_n`=0 and a write. The result is judged by reading back four locations. The new address must hold the restart beat and the next location must hold the following beat. The location the abandoned burst would have stepped to must keep its old contents, and the old burst's second beat must have landed where expected.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE = 2'd0,
      CYC_PROC = 2'd1,
      CYC_CTRL = 2'd2,
      CYC_CONT = 2'd3
   } cyc_e;
endpackage

// File: rtl/sbsram_wrdec.sv
module sbsram_wrdec #(
   parameter int LANES = 2
) (
   input  logic             all_wr_n,
   input  logic             lane_wr_n,
   input  logic [LANES-1:0] lane_en_n,
   output logic [LANES-1:0] lane_mask,
   output logic             wr_req
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      // global write covers every lane; otherwise qualifier plus own enable
      assign lane_mask[g] = !all_wr_n || (!lane_wr_n && !lane_en_n[g]);
   end
   assign wr_req = |lane_mask;
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
   import sbsram_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int BURST_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adr_proc_n,
   input  logic              adr_ctrl_n,
   input  logic              burst_adv_n,
   input  logic              sel0_n,
   input  logic              sel1_n,
   input  logic              sel2,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_req,
   output cyc_e              cyc,
   output logic              sel_ok,
   output logic              wr_go,
   output logic              rd_go,
   output logic              active,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [ADDR_W-1:0] cur_addr
);
   localparam int HI_W = ADDR_W - BURST_BITS;

   logic [ADDR_W-1:0]     cur_q;
   logic                  active_q;
   logic [BURST_BITS-1:0] lo_step;
   logic [ADDR_W-1:0]     stepped;

   assign sel_ok  = !sel0_n && !sel1_n && sel2;
   assign lo_step = cur_q[BURST_BITS-1:0] + BURST_BITS'(1);
   assign stepped = {cur_q[ADDR_W-1:BURST_BITS], lo_step};

   always_comb begin
      if (!adr_proc_n && !sel0_n)  cyc = CYC_PROC;
      else if (!adr_ctrl_n)        cyc = CYC_CTRL;
      else if (active_q)           cyc = CYC_CONT;
      else                         cyc = CYC_IDLE;
   end

   always_comb begin
      unique case (cyc)
         CYC_PROC, CYC_CTRL: eff_addr = addr;
         CYC_CONT:           eff_addr = burst_adv_n ? cur_q : stepped;
         default:            eff_addr = cur_q;
      endcase
   end

   always_comb begin
      wr_go = 1'b0;
      rd_go = 1'b0;
      unique case (cyc)
         CYC_PROC: rd_go = sel_ok;
         CYC_CTRL: begin
            wr_go = sel_ok && wr_req;
            rd_go = sel_ok && !wr_req;
         end
         CYC_CONT: begin
            wr_go = wr_req;
            rd_go = !wr_req;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q    <= '0;
         active_q <= 1'b0;
      end else begin
         if (cyc == CYC_PROC || cyc == CYC_CTRL) active_q <= sel_ok;
         if (cyc != CYC_IDLE)                    cur_q    <= eff_addr;
      end
   end

   assign cur_addr = cur_q;
   assign active   = active_q;

   if (HI_W < 1) begin : g_bad_split
      $error("burst window must leave upper address bits");
   end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       acc_addr,
   input  logic [LANES-1:0]        wr_mask,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    rd_go,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_vld
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int WORD_W = LANES * LANE_W;

   logic [WORD_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] rd_addr_q;
   logic              rd_pend_q;
   logic [WORD_W-1:0] dout_q;
   logic              vld_q;

   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (wr_mask[k]) mem[acc_addr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
      end
   end

   // stage 1: address register, stage 2: data register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_addr_q <= '0;
         rd_pend_q <= 1'b0;
         vld_q     <= 1'b0;
      end else begin
         rd_addr_q <= acc_addr;
         rd_pend_q <= rd_go;
         vld_q     <= rd_pend_q;
      end
   end

   always_ff @(posedge clk) begin
      dout_q <= mem[rd_addr_q];
   end

   assign dout     = dout_q;
   assign dout_vld = vld_q;
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
   import sbsram_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int LANE_W     = 9,
   parameter int LANES      = 2,
   parameter int BURST_BITS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adr_proc_n,
   input  logic                    adr_ctrl_n,
   input  logic                    burst_adv_n,
   input  logic                    sel0_n,
   input  logic                    sel1_n,
   input  logic                    sel2,
   input  logic                    all_wr_n,
   input  logic                    lane_wr_n,
   input  logic [LANES-1:0]        lane_en_n,
   input  logic                    out_en_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);
   localparam int WORD_W = LANES * LANE_W;

   cyc_e              cyc;
   logic              sel_ok, wr_go, rd_go, active, wr_req;
   logic              start_p, start_c, cont;
   logic [ADDR_W-1:0] eff_addr, cur_addr;
   logic [LANES-1:0]  lane_mask, wr_mask;
   logic [WORD_W-1:0] dout;
   logic              dout_vld;

   sbsram_wrdec #(.LANES(LANES)) u_wrdec (
      .all_wr_n (all_wr_n),
      .lane_wr_n(lane_wr_n),
      .lane_en_n(lane_en_n),
      .lane_mask(lane_mask),
      .wr_req   (wr_req)
   );

   sbsram_ctrl #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .adr_proc_n (adr_proc_n),
      .adr_ctrl_n (adr_ctrl_n),
      .burst_adv_n(burst_adv_n),
      .sel0_n     (sel0_n),
      .sel1_n     (sel1_n),
      .sel2       (sel2),
      .addr       (addr),
      .wr_req     (wr_req),
      .cyc        (cyc),
      .sel_ok     (sel_ok),
      .wr_go      (wr_go),
      .rd_go      (rd_go),
      .active     (active),
      .eff_addr   (eff_addr),
      .cur_addr   (cur_addr)
   );

   assign wr_mask = wr_go ? lane_mask : '0;
   assign start_p = (cyc == CYC_PROC);
   assign start_c = (cyc == CYC_CTRL);
   assign cont    = (cyc == CYC_CONT);

   sbsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_addr(eff_addr),
      .wr_mask (wr_mask),
      .wdata   (wdata),
      .rd_go   (rd_go),
      .dout    (dout),
      .dout_vld(dout_vld)
   );

   assign rdata_oe = dout_vld && !out_en_n;
   assign rdata    = rdata_oe ? dout : '0;

   if (LANES < 1 || LANE_W < 1) begin : g_bad_word
      $error("word needs at least one lane of one bit");
   end
   if (ADDR_W > 16) begin : g_bad_depth
      $error("depth too large for a simulation model");
   end
endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk #(
   parameter int ADDR_W     = 6,
   parameter int BURST_BITS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adr_proc_n,
   input logic              adr_ctrl_n,
   input logic              burst_adv_n,
   input logic              sel0_n,
   input logic              out_en_n,
   input logic [ADDR_W-1:0] addr,
   input logic              start_p,
   input logic              start_c,
   input logic              cont,
   input logic              sel_ok,
   input logic              wr_go,
   input logic              rd_go,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              rdata_oe
);
   assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((start_p || start_c) && !sel_ok) |-> !(wr_go || rd_go));

   assert_proc_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |-> !wr_go);

   assert_proc_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel0_n && !adr_proc_n && adr_ctrl_n && burst_adv_n) |=> $stable(cur_addr));

   assert_ctrl_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!adr_ctrl_n && !start_p) |=> cur_addr == $past(addr));

   assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cont && burst_adv_n) |=> $stable(cur_addr));

   assert_step_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cont && !burst_adv_n) |=>
         (cur_addr[ADDR_W-1:BURST_BITS] == $past(cur_addr[ADDR_W-1:BURST_BITS])) &&
         (cur_addr[BURST_BITS-1:0] == BURST_BITS'($past(cur_addr[BURST_BITS-1:0]) + 1'b1)));

   assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |-> ##2 (out_en_n || rdata_oe));

   assert_write_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |-> ##2 !rdata_oe);
endmodule

bind sbsram_core sbsram_core_chk #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .adr_proc_n (adr_proc_n),
   .adr_ctrl_n (adr_ctrl_n),
   .burst_adv_n(burst_adv_n),
   .sel0_n     (sel0_n),
   .out_en_n   (out_en_n),
   .addr       (addr),
   .start_p    (start_p),
   .start_c    (start_c),
   .cont       (cont),
   .sel_ok     (sel_ok),
   .wr_go      (wr_go),
   .rd_go      (rd_go),
   .cur_addr   (cur_addr),
   .rdata_oe   (rdata_oe)
);

// File: tb/test_sbsram_core.sv
module test_sbsram_core;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int AW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic proc_n, ctrl_n, adv_n, ce_n, ce2_n, ce2, gw_n, bwe_n, oe_n;
   logic [1:0]    be_n;
   logic [AW-1:0] a;
   logic [17:0]   d;
   logic [17:0]   q;
   logic          q_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   sbsram_core #(.ADDR_W(AW)) i_sbsram_core (
      .clk(clk), .rst_n(rst_n), .adr_proc_n(proc_n), .adr_ctrl_n(ctrl_n),
      .burst_adv_n(adv_n), .sel0_n(ce_n), .sel1_n(ce2_n), .sel2(ce2),
      .all_wr_n(gw_n), .lane_wr_n(bwe_n), .lane_en_n(be_n), .out_en_n(oe_n),
      .addr(a), .wdata(d), .rdata(q), .rdata_oe(q_oe)
   );

   task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      proc_n = 1; ctrl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; be_n = 2'b11;
      ce_n = 0; ce2_n = 0; ce2 = 1; oe_n = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic deselect();
      idle(); ctrl_n = 0; ce_n = 1; tick(); idle();
   endtask

   task automatic cwrite(input logic [AW-1:0] ad, input logic [17:0] dt);
      idle(); ctrl_n = 0; gw_n = 0; a = ad; d = dt; tick(); idle();
   endtask

   task automatic rd(input logic [AW-1:0] ad, output logic [17:0] dq, output logic oe);
      idle(); proc_n = 0; a = ad; tick();
      idle(); tick();
      dq = q; oe = q_oe;
      deselect();
   endtask

   task automatic expect_word(input string req, input logic [AW-1:0] ad, input logic [17:0] exp);
      logic [17:0] v;
      logic        o;
      rd(ad, v, o);
      check(req, {17'd0, o}, 18'd1);
      check(req, v, exp);
   endtask

   task automatic t_reset();
      check("R10 reset", {17'd0, q_oe}, 18'd0);
   endtask

   task automatic t_full_write_latency();
      cwrite(6'h05, 18'h2A5A5);
      deselect(); deselect();
      idle(); proc_n = 0; a = 6'h05; tick();
      check("R9 not yet", {17'd0, q_oe}, 18'd0);
      idle(); tick();
      check("R9 oe", {17'd0, q_oe}, 18'd1);
      check("R7 R9 data", q, 18'h2A5A5);
      deselect();
   endtask

   task automatic t_lane_writes();
      cwrite(6'h07, 18'h3FFFF);
      idle(); ctrl_n = 0; bwe_n = 0; be_n = 2'b10; a = 6'h07; d = 18'h00000; tick(); deselect();
      expect_word("R8 lane0 only", 6'h07, 18'h3FE00);
      idle(); ctrl_n = 0; bwe_n = 0; be_n = 2'b00; a = 6'h07; d = 18'h12345; tick(); deselect();
      expect_word("R8 both lanes", 6'h07, 18'h12345);
      idle(); ctrl_n = 0; be_n = 2'b00; a = 6'h07; d = 18'h00000; tick(); deselect();
      expect_word("R8 no write", 6'h07, 18'h12345);
      idle(); ctrl_n = 0; bwe_n = 0; be_n = 2'b01; a = 6'h07; d = 18'h00000; tick(); deselect();
      expect_word("R8 lane1 only", 6'h07, 18'h00145);
   endtask

   task automatic t_proc_start();
      cwrite(6'h09, 18'h0AAAA); deselect();
      idle(); proc_n = 0; gw_n = 0; a = 6'h09; d = 18'h15555; tick(); deselect();
      expect_word("R2 write ignored", 6'h09, 18'h0AAAA);
      idle(); proc_n = 0; gw_n = 0; a = 6'h09; d = 18'h15555; tick();
      idle(); gw_n = 0; d = 18'h01111; tick(); deselect();
      expect_word("R5 write to loaded", 6'h09, 18'h01111);
   endtask

   task automatic t_burst_wrap();
      cwrite(6'h10, 18'h2BEEF); deselect();
      idle(); ctrl_n = 0; gw_n = 0; a = 6'h0E; d = 18'h00100; tick();
      idle(); adv_n = 0; gw_n = 0; d = 18'h00101; tick();
      d = 18'h00102; tick();
      d = 18'h00103; tick();
      deselect();
      expect_word("R6 beat0", 6'h0E, 18'h00100);
      expect_word("R6 beat1", 6'h0F, 18'h00101);
      expect_word("R6 beat2 wrap", 6'h0C, 18'h00102);
      expect_word("R6 beat3", 6'h0D, 18'h00103);
      expect_word("R6 upper kept", 6'h10, 18'h2BEEF);
   endtask

   task automatic t_restart();
      cwrite(6'h22, 18'h00222); deselect();
      idle(); ctrl_n = 0; gw_n = 0; a = 6'h20; d = 18'h00200; tick();
      idle(); adv_n = 0; gw_n = 0; d = 18'h00201; tick();
      idle(); ctrl_n = 0; adv_n = 0; gw_n = 0; a = 6'h30; d = 18'h00300; tick();
      idle(); adv_n = 0; gw_n = 0; d = 18'h00301; tick();
      deselect();
      expect_word("R4 restart beat", 6'h30, 18'h00300);
      expect_word("R4 next beat", 6'h31, 18'h00301);
      expect_word("R4 old burst step", 6'h21, 18'h00201);
      expect_word("R4 old untouched", 6'h22, 18'h00222);
   endtask

   task automatic t_proc_ignored();
      cwrite(6'h3A, 18'h003AA); deselect();
      cwrite(6'h25, 18'h00255); deselect();
      idle(); ctrl_n = 0; a = 6'h25; tick();
      idle(); proc_n = 0; ce_n = 1; gw_n = 0; a = 6'h3A; d = 18'h00F0F; tick();
      deselect();
      expect_word("R3 continuation write", 6'h25, 18'h00F0F);
      expect_word("R3 strobe ignored", 6'h3A, 18'h003AA);
   endtask

   task automatic t_bad_select();
      cwrite(6'h2C, 18'h002CC); deselect();
      idle(); ctrl_n = 0; ce2 = 0; gw_n = 0; a = 6'h2C; d = 18'h00000; tick();
      idle(); gw_n = 0; d = 18'h00111; tick();
      check("R1 no output", {17'd0, q_oe}, 18'd0);
      idle(); ctrl_n = 0; ce2_n = 1; gw_n = 0; a = 6'h2C; d = 18'h00222; tick(); idle(); tick();
      expect_word("R1 no write", 6'h2C, 18'h002CC);
   endtask

   task automatic t_output_z();
      cwrite(6'h05, 18'h2A5A5); deselect();
      idle(); proc_n = 0; a = 6'h05; tick();
      idle(); oe_n = 1; tick();
      check("R10 oe high", {17'd0, q_oe}, 18'd0);
      check("R10 bus zero", q, 18'h00000);
      oe_n = 0; #1;
      check("R10 oe back", {17'd0, q_oe}, 18'd1);
      idle(); ctrl_n = 0; ce_n = 1; tick(); idle();
      check("R10 deselect delay", {17'd0, q_oe}, 18'd1);
      tick();
      check("R10 deselected", {17'd0, q_oe}, 18'd0);
      idle(); proc_n = 0; a = 6'h05; tick();
      idle(); tick();
      idle(); ctrl_n = 0; gw_n = 0; a = 6'h05; d = 18'h2A5A5; tick();
      idle(); tick();
      check("R10 after write", {17'd0, q_oe}, 18'd0);
      deselect();
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      idle(); a = '0; d = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      tick();
      t_full_write_latency();
      t_lane_writes();
      t_proc_start();
      t_burst_wrap();
      t_restart();
      t_proc_ignored();
      t_bad_select();
      t_output_z();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule